// File: doc/BRIEF.md
# Post-Update Floating-Point Load Unit

This unit carries out one floating-point load at a time. The load writes a floating-point register and then moves its base general register forward. An operation is decoded outside the unit and arrives as a set of fields: a form bit that selects displacement or indexed, a precision bit, a destination FP register index, a base register index, an index register index and a 16-bit displacement. The unit reads the base and index values from a two-port general-register read interface. It then sends one read to memory at the base value as it was before the operation, and waits for the response. When the response arrives it writes the loaded value to the FP register and writes the sum address back to the base register in the same cycle.

A single-precision load takes a 32-bit word and widens it to the 64-bit double format before it is written. Normal numbers, signed zeros, infinities, NaNs and denormals are all handled. A double-precision load passes its 64 bits through unchanged. Address arithmetic is plain modular arithmetic at the address width. An operation whose base register index is zero is rejected with a one-cycle illegal-operation pulse, and nothing else happens.

The controller has six states. IDLE accepts an operation. FETCH captures the register operands. ISSUE drives the memory request. WAIT holds until the response. COMMIT performs both register writes. REJECT raises the illegal pulse. The transitions are:
- IDLE→FETCH on acceptance with a nonzero base index.
- IDLE→REJECT on acceptance with a zero base index.
- FETCH→ISSUE, ISSUE→WAIT, COMMIT→IDLE and REJECT→IDLE, each unconditionally.
- WAIT→COMMIT when the response is valid.

Top module: `fpl_load_unit`

## Requirements
- R1: In displacement form (`op_indexed`=0) the value written to the base register is its old value plus the 16-bit displacement, sign-extended.
- R2: In indexed form (`op_indexed`=1) the value written to the base register is its old value plus the value of the index register.
- R3: Exactly one memory request is issued per legal operation. It lasts one cycle and arrives two cycles after acceptance. `mem_addr` equals the unmodified base register value, and `mem_dword` is 1 for an 8-byte read (`op_single`=0) and 0 for a 4-byte read (`op_single`=1).
- R4: For a double-precision load the FP register receives all 64 response bits unchanged.
- R5: For a single-precision load only response bits [31:0] are used, and bits [63:32] are ignored. Sign is bit 63. A normal exponent is re-biased by adding 896. The 23-bit fraction sits at bits [51:29] with zeros below it. Zero keeps its sign. Exponent 255 maps to 2047 with the fraction kept, so infinity and NaN map to their double forms.
- R6: A single-precision denormal (exponent 0, fraction nonzero) is normalised into a double normal. If the fraction's highest set bit is at position p, the exponent is 874+p and the bits below p are left-aligned into the 52-bit fraction.
- R7: An operation accepted with base index 0 gives `illegal` high for exactly the cycle after acceptance. It causes no memory request and no register write.
- R8: The FP register write and the base register write occur together in a single cycle, the cycle after the response is seen. `busy` is high from the cycle after acceptance through that write cycle, and operations offered while `busy` is high are ignored.
- R9: Address sums wrap modulo 2^XLEN without any indication.
- R10: During and directly after reset, `busy`, `mem_req`, `fpr_we`, `gpr_we` and `illegal` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is offered; taken when `busy` is low |
| op_indexed | input | 1 | 1 = indexed form, 0 = displacement form |
| op_single | input | 1 | 1 = single precision, 0 = double precision |
| op_frt | input | REG_AW | Destination FP register index |
| op_ra | input | REG_AW | Base general register index |
| op_rb | input | REG_AW | Index general register index |
| op_disp | input | DISP_W | Signed displacement |
| busy | output | 1 | An operation is in progress |
| gpr_rd_a_idx | output | REG_AW | Read port A index (base) |
| gpr_rd_a_data | input | XLEN | Read port A data, same cycle |
| gpr_rd_b_idx | output | REG_AW | Read port B index (index register) |
| gpr_rd_b_data | input | XLEN | Read port B data, same cycle |
| mem_req | output | 1 | Memory read request, one cycle |
| mem_addr | output | XLEN | Read address |
| mem_dword | output | 1 | 1 = 8-byte read, 0 = 4-byte read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data; a 4-byte read returns in bits [31:0] |
| fpr_we | output | 1 | FP register write enable |
| fpr_waddr | output | REG_AW | FP register write index |
| fpr_wdata | output | 64 | FP register write data |
| gpr_we | output | 1 | Base register write enable |
| gpr_waddr | output | REG_AW | Base register write index |
| gpr_wdata | output | XLEN | Updated address |
| illegal | output | 1 | Rejected operation, one-cycle pulse |

## Verification
A state register stuck or mis-stepped shows at the ports within one to three cycles of acceptance. The request arrives early or late, is doubled, or never comes. `busy` fails to drop the cycle after the write pair, or the two write enables split apart. A wrong captured base or sum surfaces in the write cycle as a mismatch in `mem_addr` or `gpr_wdata`. Widening errors show only in `fpr_wdata` for the affected class of single value, so zeros, infinity, NaN, normals and both extremes of the denormal range are each loaded once. A latched operation disturbed by later input activity shows when a rejected-form decoy is offered during a busy load: a spurious `illegal` pulse or a wrong write index.

// File: rtl/fpl_pkg.sv
package fpl_pkg;

    // IEEE-754 binary32 / binary64 field geometry
    localparam int SP_W        = 32;
    localparam int SP_EXP_W    = 8;
    localparam int SP_FRAC_W   = 23;
    localparam int DP_W        = 64;
    localparam int DP_EXP_W    = 11;
    localparam int DP_FRAC_W   = 52;

    localparam int SP_BIAS     = (1 << (SP_EXP_W - 1)) - 1;
    localparam int DP_BIAS     = (1 << (DP_EXP_W - 1)) - 1;
    localparam int EXP_REBIAS  = DP_BIAS - SP_BIAS;
    localparam int FRAC_PAD    = DP_FRAC_W - SP_FRAC_W;
    // double exponent of a single denormal whose top set bit is at 0
    localparam int DENORM_BASE = DP_BIAS - (SP_BIAS - 1) - SP_FRAC_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ISSUE,
        ST_WAIT,
        ST_COMMIT,
        ST_REJECT
    } fpl_state_e;

endpackage

// File: rtl/fpl_lead_one.sv
module fpl_lead_one #(
    parameter int W  = 23,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] pos
);
    // highest set bit wins (later iterations overwrite earlier ones)
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                pos = IW'(i);
            end
        end
    end
endmodule

// File: rtl/fpl_sp2dp.sv
module fpl_sp2dp
    import fpl_pkg::*;
(
    input  logic [SP_W-1:0] sp,
    output logic [DP_W-1:0] dp
);
    localparam int PW = $clog2(SP_FRAC_W);
    localparam int SW = PW + 1;

    logic                 sgn;
    logic [SP_EXP_W-1:0]  exp_s;
    logic [SP_FRAC_W-1:0] frac_s;
    logic [PW-1:0]        top_pos;
    logic [SW-1:0]        shamt;
    logic [DP_FRAC_W:0]   norm_frac;

    assign sgn    = sp[SP_W-1];
    assign exp_s  = sp[SP_W-2 -: SP_EXP_W];
    assign frac_s = sp[SP_FRAC_W-1:0];

    fpl_lead_one #(.W(SP_FRAC_W)) u_lead (
        .vec (frac_s),
        .pos (top_pos)
    );

    // shift so the leading one falls off the top of the 52-bit fraction
    assign shamt     = SW'(SP_FRAC_W) - SW'(top_pos);
    assign norm_frac = {1'b0, frac_s, {FRAC_PAD{1'b0}}} << shamt;

    always_comb begin
        if (exp_s == '0 && frac_s == '0) begin
            dp = {sgn, {(DP_W-1){1'b0}}};
        end else if (exp_s == '0) begin
            dp = {sgn, DP_EXP_W'(DENORM_BASE) + DP_EXP_W'(top_pos),
                  norm_frac[DP_FRAC_W-1:0]};
        end else if (exp_s == '1) begin
            dp = {sgn, {DP_EXP_W{1'b1}}, frac_s, {FRAC_PAD{1'b0}}};
        end else begin
            dp = {sgn, DP_EXP_W'(exp_s) + DP_EXP_W'(EXP_REBIAS),
                  frac_s, {FRAC_PAD{1'b0}}};
        end
    end
endmodule

// File: rtl/fpl_ea_gen.sv
module fpl_ea_gen #(
    parameter int XLEN   = 64,
    parameter int DISP_W = 16,
    localparam int EXT_W = XLEN - DISP_W
) (
    input  logic [XLEN-1:0]   base,
    input  logic [XLEN-1:0]   index,
    input  logic [DISP_W-1:0] disp,
    input  logic              indexed,
    output logic [XLEN-1:0]   ea
);
    logic [XLEN-1:0] disp_ext;
    logic [XLEN-1:0] addend;

    assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    assign addend   = indexed ? index : disp_ext;
    assign ea       = base + addend;   // modular, no carry out
endmodule

// File: rtl/fpl_load_unit.sv
module fpl_load_unit
    import fpl_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int REG_AW = 5,
    parameter int DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_indexed,
    input  logic              op_single,
    input  logic [REG_AW-1:0] op_frt,
    input  logic [REG_AW-1:0] op_ra,
    input  logic [REG_AW-1:0] op_rb,
    input  logic [DISP_W-1:0] op_disp,
    output logic              busy,
    output logic [REG_AW-1:0] gpr_rd_a_idx,
    input  logic [XLEN-1:0]   gpr_rd_a_data,
    output logic [REG_AW-1:0] gpr_rd_b_idx,
    input  logic [XLEN-1:0]   gpr_rd_b_data,
    output logic              mem_req,
    output logic [XLEN-1:0]   mem_addr,
    output logic              mem_dword,
    input  logic              mem_rsp_valid,
    input  logic [DP_W-1:0]   mem_rsp_data,
    output logic              fpr_we,
    output logic [REG_AW-1:0] fpr_waddr,
    output logic [DP_W-1:0]   fpr_wdata,
    output logic              gpr_we,
    output logic [REG_AW-1:0] gpr_waddr,
    output logic [XLEN-1:0]   gpr_wdata,
    output logic              illegal
);

    fpl_state_e state_q, state_d;

    logic              indexed_q;
    logic              single_q;
    logic [REG_AW-1:0] frt_q;
    logic [REG_AW-1:0] ra_q;
    logic [REG_AW-1:0] rb_q;
    logic [DISP_W-1:0] disp_q;
    logic [XLEN-1:0]   base_q;
    logic [XLEN-1:0]   ea_q;
    logic [XLEN-1:0]   ea_c;
    logic [DP_W-1:0]   data_q;
    logic [DP_W-1:0]   widened_c;
    logic              accept;
    logic              ra_is_zero;

    assign accept     = op_valid && (state_q == ST_IDLE);
    assign ra_is_zero = (op_ra == '0);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ra_is_zero ? ST_REJECT : ST_FETCH;
                end
            end
            ST_FETCH:  state_d = ST_ISSUE;
            ST_ISSUE:  state_d = ST_WAIT;
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    state_d = ST_COMMIT;
                end
            end
            ST_COMMIT: state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            indexed_q <= 1'b0;
            single_q  <= 1'b0;
            frt_q     <= '0;
            ra_q      <= '0;
            rb_q      <= '0;
            disp_q    <= '0;
            base_q    <= '0;
            ea_q      <= '0;
            data_q    <= '0;
        end else begin
            if (accept) begin
                indexed_q <= op_indexed;
                single_q  <= op_single;
                frt_q     <= op_frt;
                ra_q      <= op_ra;
                rb_q      <= op_rb;
                disp_q    <= op_disp;
            end
            if (state_q == ST_FETCH) begin
                base_q <= gpr_rd_a_data;
                ea_q   <= ea_c;
            end
            if (state_q == ST_WAIT && mem_rsp_valid) begin
                data_q <= mem_rsp_data;
            end
        end
    end

    fpl_ea_gen #(.XLEN(XLEN), .DISP_W(DISP_W)) u_ea (
        .base    (gpr_rd_a_data),
        .index   (gpr_rd_b_data),
        .disp    (disp_q),
        .indexed (indexed_q),
        .ea      (ea_c)
    );

    fpl_sp2dp u_widen (
        .sp (data_q[SP_W-1:0]),
        .dp (widened_c)
    );

    // ---------------- outputs ----------------
    always_comb begin
        busy         = (state_q != ST_IDLE);
        gpr_rd_a_idx = ra_q;
        gpr_rd_b_idx = rb_q;
        mem_req      = 1'b0;
        mem_addr     = base_q;
        mem_dword    = ~single_q;
        fpr_we       = 1'b0;
        fpr_waddr    = frt_q;
        fpr_wdata    = single_q ? widened_c : data_q;
        gpr_we       = 1'b0;
        gpr_waddr    = ra_q;
        gpr_wdata    = ea_q;
        illegal      = 1'b0;
        unique case (state_q)
            ST_ISSUE:  mem_req = 1'b1;
            ST_COMMIT: begin
                fpr_we = 1'b1;
                gpr_we = 1'b1;
            end
            ST_REJECT: illegal = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/fpl_load_unit_chk.sv
module fpl_load_unit_chk #(
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [REG_AW-1:0] op_ra,
    input logic              busy,
    input logic              mem_req,
    input logic              fpr_we,
    input logic              gpr_we,
    input logic [REG_AW-1:0] gpr_waddr,
    input logic              illegal
);

    p_reject_ra0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && op_ra == '0) |=> (illegal && !mem_req));

    p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!fpr_we && !gpr_we && !mem_req));

    p_paired_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fpr_we |-> gpr_we);

    p_activity_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fpr_we || mem_req || illegal) |-> busy);

    p_accept_sets_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy) |=> busy);

    p_idle_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fpr_we |=> !busy);

    p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    p_base_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_we |-> (gpr_waddr != '0));

endmodule

bind fpl_load_unit fpl_load_unit_chk #(.REG_AW(REG_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_ra     (op_ra),
    .busy      (busy),
    .mem_req   (mem_req),
    .fpr_we    (fpr_we),
    .gpr_we    (gpr_we),
    .gpr_waddr (gpr_waddr),
    .illegal   (illegal)
);

// File: tb/fpl_load_unit_bench.sv
module fpl_load_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic        op_indexed;
    logic        op_single;
    logic [4:0]  op_frt, op_ra, op_rb;
    logic [15:0] op_disp;
    logic        busy;
    logic [4:0]  gpr_rd_a_idx, gpr_rd_b_idx;
    logic [63:0] gpr_rd_a_data, gpr_rd_b_data;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_dword;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        fpr_we, gpr_we, illegal;
    logic [4:0]  fpr_waddr, gpr_waddr;
    logic [63:0] fpr_wdata, gpr_wdata;

    logic [63:0] gpr [32];

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  expect_illegal = 1'b0;
    bit  done = 1'b0;

    // expected write records, filled by stimulus, drained by the monitor
    int          q_frt [$];
    int          q_ra  [$];
    logic [63:0] q_fval[$];
    logic [63:0] q_ea  [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign gpr_rd_a_data = gpr[gpr_rd_a_idx];
    assign gpr_rd_b_data = gpr[gpr_rd_b_idx];

    fpl_load_unit u_fpl_load_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
        .op_indexed(op_indexed), .op_single(op_single),
        .op_frt(op_frt), .op_ra(op_ra), .op_rb(op_rb), .op_disp(op_disp),
        .busy(busy),
        .gpr_rd_a_idx(gpr_rd_a_idx), .gpr_rd_a_data(gpr_rd_a_data),
        .gpr_rd_b_idx(gpr_rd_b_idx), .gpr_rd_b_data(gpr_rd_b_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_dword(mem_dword),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .fpr_we(fpr_we), .fpr_waddr(fpr_waddr), .fpr_wdata(fpr_wdata),
        .gpr_we(gpr_we), .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata),
        .illegal(illegal)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural single -> double widening, normalising by repeated shift
    function automatic logic [63:0] ref_widen(input logic [31:0] w);
        logic [23:0] m;
        int          e;
        int          de;
        e = int'(w[30:23]);
        if (e == 255) return {w[31], 11'h7FF, w[22:0], 29'b0};
        if (e == 0 && w[22:0] == 23'b0) return {w[31], 63'b0};
        if (e == 0) begin
            m  = {1'b0, w[22:0]};
            de = 897;
            while (!m[23]) begin
                m  = m << 1;
                de = de - 1;
            end
            return {w[31], 11'(de), m[22:0], 29'b0};
        end
        return {w[31], 11'(e + 896), w[22:0], 29'b0};
    endfunction

    // per-clock monitor against the expected-write queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (fpr_we !== gpr_we)
                chk(1'b0, "R8 paired write", {63'b0, fpr_we}, {63'b0, gpr_we});
            if (illegal && !expect_illegal)
                chk(1'b0, "R8 spurious illegal", 64'd1, 64'd0);
            if (fpr_we === 1'b1) begin
                if (q_frt.size() == 0) begin
                    chk(1'b0, "R8 unexpected write", 64'd1, 64'd0);
                end else begin
                    chk(fpr_waddr == 5'(q_frt[0]), "R8 fpr index",
                        64'(fpr_waddr), 64'(q_frt[0]));
                    chk(fpr_wdata == q_fval[0], "R4/R5/R6 fpr data",
                        fpr_wdata, q_fval[0]);
                    chk(gpr_waddr == 5'(q_ra[0]), "R1/R2 base index",
                        64'(gpr_waddr), 64'(q_ra[0]));
                    chk(gpr_wdata == q_ea[0], "R1/R2/R9 updated address",
                        gpr_wdata, q_ea[0]);
                    void'(q_frt.pop_front());
                    void'(q_ra.pop_front());
                    void'(q_fval.pop_front());
                    void'(q_ea.pop_front());
                end
            end
        end
    end

    task automatic run_op(input bit idx, input bit sgl, input int frt,
                          input int ra, input int rb, input logic [15:0] disp,
                          input logic [63:0] rsp, input int lat, input bit decoy,
                          input string tag);
        logic [63:0] base;
        logic [63:0] ea;
        logic [63:0] fval;
        base = gpr[ra];
        ea   = idx ? base + gpr[rb] : base + {{48{disp[15]}}, disp};
        fval = sgl ? ref_widen(rsp[31:0]) : rsp;
        @(negedge clk);
        op_valid   = 1'b1;
        op_indexed = idx;
        op_single  = sgl;
        op_frt     = 5'(frt);
        op_ra      = 5'(ra);
        op_rb      = 5'(rb);
        op_disp    = disp;
        if (ra == 0) begin
            expect_illegal = 1'b1;
        end else begin
            q_frt.push_back(frt);
            q_ra.push_back(ra);
            q_fval.push_back(fval);
            q_ea.push_back(ea);
        end
        @(negedge clk);
        chk(busy == 1'b1, {tag, " R8 busy after accept"}, 64'(busy), 64'd1);
        if (decoy) begin
            op_ra = 5'd0; op_frt = 5'd31; op_indexed = ~idx; op_single = ~sgl;
        end else begin
            op_valid = 1'b0;
        end
        if (ra == 0) begin
            chk(illegal == 1'b1, {tag, " R7 illegal pulse"}, 64'(illegal), 64'd1);
            chk(!mem_req && !fpr_we && !gpr_we, {tag, " R7 no side effect"},
                {61'b0, mem_req, fpr_we, gpr_we}, 64'd0);
            @(negedge clk);
            chk(!illegal && !busy && !mem_req, {tag, " R7 pulse ends"},
                {62'b0, illegal, busy}, 64'd0);
            expect_illegal = 1'b0;
            return;
        end
        chk(mem_req == 1'b0, {tag, " R3 no early request"}, 64'(mem_req), 64'd0);
        @(negedge clk);
        chk(mem_req == 1'b1, {tag, " R3 request timing"}, 64'(mem_req), 64'd1);
        chk(mem_addr == base, {tag, " R3 old base address"}, mem_addr, base);
        chk(mem_dword == !sgl, {tag, " R3 access size"}, 64'(mem_dword), 64'(!sgl));
        repeat (lat) begin
            @(negedge clk);
            chk(!mem_req && !fpr_we, {tag, " R3 single request"},
                {62'b0, mem_req, fpr_we}, 64'd0);
        end
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rsp;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 64'hA5A5_5A5A_0F0F_F0F0;
        chk(fpr_we && gpr_we && busy, {tag, " R8 write cycle"},
            {61'b0, fpr_we, gpr_we, busy}, 64'd7);
        op_valid = 1'b0;
        @(negedge clk);
        chk(!busy && !fpr_we && !gpr_we, {tag, " R8 back to idle"},
            {61'b0, busy, fpr_we, gpr_we}, 64'd0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) gpr[i] = 64'(i) * 64'h0101;
        rst_n = 1'b0; op_valid = 1'b0; op_indexed = 1'b0; op_single = 1'b0;
        op_frt = '0; op_ra = '0; op_rb = '0; op_disp = '0;
        mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !fpr_we && !gpr_we && !illegal, "R10 in reset",
            {59'b0, busy, mem_req, fpr_we, gpr_we, illegal}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req && !fpr_we && !gpr_we && !illegal, "R10 after reset",
            {59'b0, busy, mem_req, fpr_we, gpr_we, illegal}, 64'd0);

        // R1 R3 R4: double, positive displacement
        gpr[3] = 64'h1000;
        run_op(0, 0, 7, 3, 0, 16'h0040, 64'h4009_21FB_5444_2D18, 1, 0, "R1 R4 pos disp");
        // R1: negative displacement
        gpr[5] = 64'h2000;
        run_op(0, 0, 2, 5, 0, 16'hFFF8, 64'hC000_0000_0000_0001, 3, 0, "R1 neg disp");
        // R2 R5: indexed single, upper response half must be ignored
        gpr[6] = 64'h3000; gpr[9] = 64'h100;
        run_op(1, 1, 4, 6, 9, 16'h7777, 64'hDEAD_BEEF_3FC0_0000, 2, 0, "R2 R5 indexed normal");
        // R5: special values
        gpr[8] = 64'h4000;
        run_op(0, 1, 1, 8, 0, 16'h0004, 64'hFFFF_FFFF_8000_0000, 1, 0, "R5 neg zero");
        run_op(0, 1, 1, 8, 0, 16'h0004, 64'h0000_0000_7F80_0000, 1, 0, "R5 infinity");
        run_op(0, 1, 1, 8, 0, 16'h0004, 64'h1234_5678_7FC0_0001, 2, 0, "R5 nan");
        run_op(1, 1, 12, 8, 9, 16'h0000, 64'h0000_0000_C2F6_E979, 1, 0, "R5 negative normal");
        // R6: denormal extremes and a middle one
        gpr[10] = 64'h5000;
        run_op(0, 1, 13, 10, 0, 16'h0008, 64'h0000_0000_0000_0001, 1, 0, "R6 smallest denormal");
        run_op(0, 1, 14, 10, 0, 16'h0008, 64'h0000_0000_807F_FFFF, 2, 0, "R6 largest denormal");
        run_op(0, 1, 15, 10, 0, 16'h0008, 64'h0000_0000_0001_2345, 1, 0, "R6 mid denormal");
        // R9: wraparound in both forms
        gpr[11] = 64'hFFFF_FFFF_FFFF_FFF0; gpr[12] = 64'h20;
        run_op(1, 0, 20, 11, 12, 16'h0000, 64'h0123_4567_89AB_CDEF, 1, 0, "R9 indexed wrap");
        gpr[13] = 64'h8;
        run_op(0, 0, 21, 13, 0, 16'hFFF0, 64'h0F0F_0F0F_0F0F_0F0F, 1, 0, "R9 disp wrap");
        // R7: zero base index, both forms
        run_op(0, 0, 22, 0, 0, 16'h0010, 64'h0, 1, 0, "R7 disp form");
        run_op(1, 1, 23, 0, 5, 16'h0000, 64'h0, 1, 0, "R7 indexed form");
        // R8: offers while busy are ignored
        gpr[14] = 64'h6000;
        run_op(0, 0, 24, 14, 0, 16'h0100, 64'h7FF0_0000_0000_0000, 3, 1, "R8 busy decoy");
        repeat (2) @(negedge clk);
        chk(q_frt.size() == 0, "R8 all writes seen", 64'(q_frt.size()), 64'd0);
        chk(!busy && !illegal, "R8 idle at end", {62'b0, busy, illegal}, 64'd0);
        finish_run();
    end

endmodule